// File: doc/BRIEF.md
# Trap Service Sequencer

This block carries out the console service requests that a small 16-bit processor core raises through its trap instruction. The core hands over an 8-bit service number with a one-cycle request strobe, together with the current contents of its register R0. The sequencer then runs the matching service. It reads characters from an input byte stream and sends characters to an output byte stream. It walks zero-terminated strings through a synchronous memory read port. It moves raw 16-bit values as byte pairs. It can also stop the machine. When a service ends, the block pulses `done`. A service that fetches data writes its result back to R0 through a write-enable and data pair.

Both byte streams use valid/ready. A byte moves only at a rising edge where valid and ready are both high. On the output side, the sequencer keeps `tx_valid` high and `tx_data` unchanged for as long as `tx_ready` stays low, so the consumer can stall it for any number of cycles. On the input side, `rx_ready` is high only while a service is waiting for a byte. Any byte offered at other times is not taken. The memory port has one cycle of read latency: the word at `mem_addr` must be on `mem_rdata` in the cycle after `mem_re` is high.

Top module: `trap_io_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done`, `halt`, `illegal`, `r0_we`, `tx_valid`, `rx_ready` and `mem_re` are all low. Reset also clears a halt that was raised earlier.
- R2: Service 0x20 raises `rx_ready` and waits for one input byte. In the cycle after that byte is accepted, `r0_we` and `done` are both high, and `r0_wdata` holds the byte zero-extended to 16 bits.
- R3: Service 0x21 sends bits 7:0 of `r0_value` (sampled with the request) as one output byte. `done` is high in the cycle after that byte is accepted.
- R4: Service 0x22 reads words from address `r0_value` upward, one word per step. For each word that is not zero, it sends bits 7:0 of the word. It stops at the first word equal to 0x0000 and does not send that word. `done` comes three cycles after the last accepted byte, or three cycles after the request when the string is empty.
- R5: Service 0x23 reads one byte and writes it to R0, zero-extended. It then sends that same byte once on the output. `done` comes in the cycle after the echo byte is accepted.
- R6: Service 0x25 sets `halt` and pulses `done` in the cycle after the request. `halt` then stays high until reset, while later services still run.
- R7: Service 0x26 takes two input bytes, the high byte first. In the cycle after the second byte is accepted, it writes both bytes to R0 as one 16-bit value, with `done` in the same cycle.
- R8: Service 0x27 sends `r0_value` as two output bytes, bits 15:8 first and then bits 7:0. `done` comes in the cycle after the second byte is accepted.
- R9: Service 0x24, and any number below 0x20 or above 0x27, raises `illegal` together with `done` in the cycle after the request. In that case the block makes no R0 write and sends no output byte.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged in the next cycle.
- R11: `done` is high for exactly one cycle per service. A request strobe that arrives while a service is running, or in the cycle of its `done`, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One-cycle service request strobe |
| req_vector | input | 8 | Service number, sampled with the strobe |
| r0_value | input | 16 | Current contents of R0, sampled with the strobe |
| mem_rdata | input | 16 | Memory word for the address presented in the previous cycle |
| rx_valid | input | 1 | Input byte present |
| rx_data | input | 8 | Input byte |
| rx_ready | output | 1 | Sequencer will accept an input byte |
| tx_valid | output | 1 | Output byte present |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Consumer accepts the output byte |
| r0_we | output | 1 | One-cycle R0 write enable |
| r0_wdata | output | 16 | Value to write to R0 |
| mem_addr | output | 16 | Memory word address |
| mem_re | output | 1 | Memory read enable |
| done | output | 1 | One-cycle service completion pulse |
| halt | output | 1 | Machine stop flag, held until reset |
| illegal | output | 1 | Unsupported service number, high together with done |

## Verification
Each result has a fixed latency, counted from the last stream handshake of the service, or from the request itself when the service has no handshake. `done`, the R0 write and `illegal` are due one cycle later. For a string walk, `done` is due three cycles later, because the final zero word still has to be read and examined. The bench numbers every falling edge of a service and records the edge at which it drove the last handshake. It then requires `done` at exactly that edge plus the latency above, and sees it only once in the cycles that follow. Output bytes are captured at the falling edge that comes before an accepting rising edge. While the consumer stalls, every stalled edge is compared with the byte that was held, so both the order of the bytes and their stability are checked.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;

  typedef enum logic [2:0] {
    OP_GETC, OP_PUTC, OP_PUTS, OP_GETE, OP_HALT, OP_NIN, OP_NOUT, OP_BAD
  } trap_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX1, ST_RX2, ST_TXHI, ST_TXW, ST_SRD, ST_SCHK, ST_STX, ST_FIN
  } seq_state_e;

endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trapseq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
  input  logic [VEC_W-1:0] vector,
  output trap_op_e         op
);
  localparam int NUM_VEC = 8;

  logic [VEC_W-1:0] idx;
  logic             in_range;

  assign idx      = vector - VEC_BASE;
  assign in_range = (vector >= VEC_BASE) && (idx < VEC_W'(NUM_VEC));

  always_comb begin
    op = OP_BAD;
    if (in_range) begin
      case (idx[2:0])
        3'd0:    op = OP_GETC;
        3'd1:    op = OP_PUTC;
        3'd2:    op = OP_PUTS;
        3'd3:    op = OP_GETE;
        3'd5:    op = OP_HALT;
        3'd6:    op = OP_NIN;
        3'd7:    op = OP_NOUT;
        default: op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              sent
);
  assign sent = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (sent) begin
      tx_valid <= 1'b0;
    end
  end

  // R10: a stalled byte stays offered and unchanged
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R10: a new byte is loaded only when the slot is free or being emptied
  assert_load_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!tx_valid || tx_ready));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trapseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  trap_op_e          op,
  input  logic [DATA_W-1:0] r0_value,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              tx_sent,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              r0_we,
  output logic [DATA_W-1:0] r0_wdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              done,
  output logic              halt,
  output logic              illegal
);
  localparam int PAD_W = DATA_W - BYTE_W;

  seq_state_e        state, state_n;
  trap_op_e          op_q, op_n;
  logic [DATA_W-1:0] addr_q, addr_n;
  logic [BYTE_W-1:0] hold_q, hold_n;
  logic              ill_q, ill_n;
  logic              halt_q, halt_n;
  logic              we_q, we_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              rx_fire;

  assign rx_ready = (state == ST_RX1) || (state == ST_RX2);
  assign rx_fire  = rx_valid && rx_ready;
  assign mem_re   = (state == ST_SRD);
  assign mem_addr = addr_q;
  assign done     = (state == ST_FIN);
  assign illegal  = done && ill_q;
  assign halt     = halt_q;
  assign r0_we    = we_q;
  assign r0_wdata = wd_q;

  always_comb begin
    state_n = state;
    op_n    = op_q;
    addr_n  = addr_q;
    hold_n  = hold_q;
    ill_n   = ill_q;
    halt_n  = halt_q;
    we_n    = 1'b0;
    wd_n    = wd_q;
    tx_load = 1'b0;
    tx_byte = '0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          op_n  = op;
          ill_n = 1'b0;
          case (op)
            OP_GETC, OP_GETE, OP_NIN: state_n = ST_RX1;
            OP_PUTC: begin
              tx_load = 1'b1;
              tx_byte = r0_value[BYTE_W-1:0];
              state_n = ST_TXW;
            end
            OP_PUTS: begin
              addr_n  = r0_value;
              state_n = ST_SRD;
            end
            OP_HALT: begin
              halt_n  = 1'b1;
              state_n = ST_FIN;
            end
            OP_NOUT: begin
              tx_load = 1'b1;
              tx_byte = r0_value[DATA_W-1:BYTE_W];
              hold_n  = r0_value[BYTE_W-1:0];
              state_n = ST_TXHI;
            end
            default: begin
              ill_n   = 1'b1;
              state_n = ST_FIN;
            end
          endcase
        end
      end
      ST_RX1: begin
        if (rx_fire) begin
          if (op_q == OP_NIN) begin
            hold_n  = rx_data;
            state_n = ST_RX2;
          end else begin
            we_n = 1'b1;
            wd_n = {{PAD_W{1'b0}}, rx_data};
            if (op_q == OP_GETE) begin
              tx_load = 1'b1;
              tx_byte = rx_data;
              state_n = ST_TXW;
            end else begin
              state_n = ST_FIN;
            end
          end
        end
      end
      ST_RX2: begin
        if (rx_fire) begin
          we_n    = 1'b1;
          wd_n    = {hold_q, rx_data};
          state_n = ST_FIN;
        end
      end
      ST_TXHI: begin
        if (tx_sent) begin
          tx_load = 1'b1;
          tx_byte = hold_q;
          state_n = ST_TXW;
        end
      end
      ST_TXW: begin
        if (tx_sent) state_n = ST_FIN;
      end
      ST_SRD:  state_n = ST_SCHK;
      ST_SCHK: begin
        if (mem_rdata == '0) begin
          state_n = ST_FIN;
        end else begin
          tx_load = 1'b1;
          tx_byte = mem_rdata[BYTE_W-1:0];
          addr_n  = addr_q + DATA_W'(1);
          state_n = ST_STX;
        end
      end
      ST_STX: begin
        if (tx_sent) state_n = ST_SRD;
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_BAD;
      addr_q <= '0;
      hold_q <= '0;
      ill_q  <= 1'b0;
      halt_q <= 1'b0;
      we_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      state  <= state_n;
      op_q   <= op_n;
      addr_q <= addr_n;
      hold_q <= hold_n;
      ill_q  <= ill_n;
      halt_q <= halt_n;
      we_q   <= we_n;
      wd_q   <= wd_n;
    end
  end

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: halt stays set until reset
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R9: an unsupported service never writes R0
  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !r0_we);

  // R4: every memory read is followed by a cycle that examines the word
  assert_read_then_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!mem_re && !rx_ready && !done));

  // R7: an R0 write lasts one cycle
  assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    r0_we |=> !r0_we);

  // R2: no input is taken in the completion cycle
  assert_rx_not_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !done);
endmodule

// File: rtl/trap_io_seq.sv
module trap_io_seq
  import trapseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic [DATA_W-1:0] r0_value,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W/2-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W/2-1:0] tx_data,
  input  logic              tx_ready,
  output logic              r0_we,
  output logic [DATA_W-1:0] r0_wdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              done,
  output logic              halt,
  output logic              illegal
);
  localparam int BYTE_W = DATA_W / 2;

  trap_op_e          op;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_sent;

  trap_decode #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_decode (
    .vector (req_vector),
    .op     (op)
  );

  trap_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op        (op),
    .r0_value  (r0_value),
    .mem_rdata (mem_rdata),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .tx_sent   (tx_sent),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .r0_we     (r0_we),
    .r0_wdata  (r0_wdata),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .done      (done),
    .halt      (halt),
    .illegal   (illegal)
  );

  trap_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_data (tx_byte),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .sent      (tx_sent)
  );
endmodule

// File: tb/trap_io_seq_test.sv
`timescale 1ns/1ps
module trap_io_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic [15:0] r0_value = '0;
  logic [15:0] mem_rdata = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, r0_we, mem_re, done, halt, illegal;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic [15:0] r0_wdata, mem_addr;

  int errors = 0;
  int checks = 0;
  logic halt_exp = 1'b0;
  logic [15:0] mem [0:15];

  always #2 clk = ~clk;

  trap_io_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .r0_value(r0_value), .mem_rdata(mem_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .r0_we(r0_we), .r0_wdata(r0_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .done(done), .halt(halt),
    .illegal(illegal)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr[3:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // table: {vector, r0, rx byte 0, rx byte 1, stall}
  localparam int NV = 15;
  localparam logic [40:0] TBL [0:NV-1] = '{
    {8'h20, 16'h0000, 8'h41, 8'h00, 1'b0},
    {8'h20, 16'hFFFF, 8'hC3, 8'h00, 1'b1},
    {8'h21, 16'h1234, 8'h00, 8'h00, 1'b1},
    {8'h21, 16'hAB7E, 8'h00, 8'h00, 1'b0},
    {8'h22, 16'h0004, 8'h00, 8'h00, 1'b1},
    {8'h22, 16'h000A, 8'h00, 8'h00, 1'b0},
    {8'h23, 16'h0000, 8'h7A, 8'h00, 1'b1},
    {8'h26, 16'h1111, 8'hBE, 8'hEF, 1'b0},
    {8'h27, 16'hC0DE, 8'h00, 8'h00, 1'b1},
    {8'h24, 16'h0004, 8'h55, 8'h66, 1'b0},
    {8'h1F, 16'h0004, 8'h55, 8'h66, 1'b0},
    {8'h28, 16'h0004, 8'h55, 8'h66, 1'b0},
    {8'hFF, 16'h0004, 8'h55, 8'h66, 1'b0},
    {8'h25, 16'h0000, 8'h00, 8'h00, 1'b0},
    {8'h21, 16'h0031, 8'h00, 8'h00, 1'b1}
  };

  task automatic run_trap(input logic [7:0] vec, input logic [15:0] r0,
                          input logic [7:0] b0, input logic [7:0] b1,
                          input logic stall);
    logic [7:0] cap [0:15];
    logic [7:0] exp_tx [0:15];
    int ncap = 0, nexp = 0, nwe = 0, ndone = 0, n = 0, n_last = 0, n_done = -1;
    int rxi = 0, lat;
    logic [15:0] wd = '0, exp_wd = '0;
    logic ill_seen = 1'b0, exp_ill = 1'b0, wa = 1'b0, holding = 1'b0;
    logic [7:0] held = '0;
    int exp_we = 0;
    string tag;

    case (vec)
      8'h20: begin tag = "R2"; exp_we = 1; exp_wd = {8'h00, b0}; end
      8'h21: begin tag = "R3"; exp_tx[0] = r0[7:0]; nexp = 1; end
      8'h22: begin
        tag = "R4";
        for (int a = 0; a < 16; a++) begin
          if (mem[(r0[3:0] + a) % 16] == 16'h0000) break;
          exp_tx[nexp] = mem[(r0[3:0] + a) % 16][7:0];
          nexp++;
        end
      end
      8'h23: begin tag = "R5"; exp_we = 1; exp_wd = {8'h00, b0}; exp_tx[0] = b0; nexp = 1; end
      8'h25: begin tag = "R6"; halt_exp = 1'b1; end
      8'h26: begin tag = "R7"; exp_we = 1; exp_wd = {b0, b1}; end
      8'h27: begin tag = "R8"; exp_tx[0] = r0[15:8]; exp_tx[1] = r0[7:0]; nexp = 2; end
      default: begin tag = "R9"; exp_ill = 1'b1; end
    endcase
    lat = (vec == 8'h22) ? 3 : 1;

    @(negedge clk);
    req_vector = vec; r0_value = r0; req_valid = 1'b1;
    rx_valid = 1'b0; tx_ready = 1'b1;
    while (n < 400) begin
      @(negedge clk);
      n++;
      req_valid = 1'b0;
      if (wa) rxi++;
      if (holding)
        chk(tx_valid && tx_data == held, "R10", "stalled byte", int'(tx_data), int'(held));
      if (done) begin
        ndone++;
        if (n_done < 0) begin n_done = n; ill_seen = illegal; end
      end
      if (r0_we) begin nwe++; wd = r0_wdata; end
      if (n_done >= 0 && n >= n_done + 3) break;
      rx_valid = (rxi < 2);
      rx_data  = (rxi == 0) ? b0 : b1;
      tx_ready = stall ? (n % 3 == 2) : 1'b1;
      wa = rx_valid && rx_ready;
      if (wa) n_last = n;
      if (tx_valid && tx_ready) begin
        if (ncap < 16) cap[ncap] = tx_data;
        ncap++;
        n_last = n;
      end
      holding = tx_valid && !tx_ready;
      held = tx_data;
    end
    rx_valid = 1'b0; tx_ready = 1'b1;

    chk(ndone == 1, "R11", "done pulses", ndone, 1);
    chk(n_done == n_last + lat, tag, "done latency", n_done, n_last + lat);
    chk(ncap == nexp, tag, "output byte count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      chk(cap[i] == exp_tx[i], tag, "output byte", int'(cap[i]), int'(exp_tx[i]));
    chk(nwe == exp_we, tag, "R0 writes", nwe, exp_we);
    if (exp_we == 1) chk(wd == exp_wd, tag, "R0 value", int'(wd), int'(exp_wd));
    chk(ill_seen == exp_ill, tag, "illegal flag", int'(ill_seen), int'(exp_ill));
    chk(halt == halt_exp, "R6", "halt level", int'(halt), int'(halt_exp));
  endtask

  task automatic reset_check(input string what);
    chk(!done && !halt && !illegal && !r0_we && !tx_valid && !rx_ready && !mem_re,
        "R1", what, int'({done, halt, illegal, r0_we, tx_valid, rx_ready, mem_re}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h5A5A;
    mem[4] = 16'hA548; mem[5] = 16'h0069; mem[6] = 16'hFF21; mem[7] = 16'h0000;
    mem[10] = 16'h0000;

    // R1: reset state
    repeat (3) @(negedge clk);
    reset_check("outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("outputs after reset");

    // R11: request while busy is ignored
    begin
      int nd = 0, nbyte = 0;
      logic hold_ok = 1'b1;
      @(negedge clk);
      req_vector = 8'h21; r0_value = 16'h0055; req_valid = 1'b1; tx_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_vector = 8'h25; req_valid = 1'b1;
      repeat (2) begin
        @(negedge clk);
        if (!(tx_valid && tx_data == 8'h55)) hold_ok = 1'b0;
      end
      req_valid = 1'b0;
      chk(hold_ok, "R10", "byte held while stalled", int'(tx_data), 'h55);
      tx_ready = 1'b1;
      if (tx_valid) nbyte++;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done) nd++;
        if (tx_valid && tx_ready) nbyte++;
      end
      chk(nd == 1, "R11", "done count with busy request", nd, 1);
      chk(nbyte == 1, "R11", "bytes sent with busy request", nbyte, 1);
      chk(!halt, "R11", "halt after ignored request", int'(halt), 0);
    end

    for (int t = 0; t < NV; t++)
      run_trap(TBL[t][40:33], TBL[t][32:17], TBL[t][16:9], TBL[t][8:1], TBL[t][0]);

    // R1: reset clears a raised halt
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("halt cleared by reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule